// File: doc/BRIEF.md
# Round-Robin Slave Port Arbiter with Idle Parking and Burst Cutoff

This block guards one slave port of a multi-master bus matrix. Up to six masters raise requests; the arbiter returns a registered one-hot grant naming the single master that currently owns the port. The masters are indexed 0 to 5: CPU data, CPU instruction, CPU system access, peripheral DMA, Ethernet DMA and USB DMA. Among simultaneous requesters the winner is chosen round-robin, starting from the master after the one that last held the port.

Ownership changes only when the owner is not requesting or signals the end of its current transfer. A master that flags a burst keeps the port across transfer ends until its slot of cycles runs out, after which any competing requester wins at the next transfer end. When nobody requests, a per-instance policy input decides whether the port is released, kept by the last owner, or handed to a fixed master. Each slave port gets its own instance with its own configuration.

Top module: `busmat_slave_arb`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with no request, gnt_o is all zero.
- R2: gnt_o is always one-hot or all zero, and is driven from registers only, so it changes only at a rising clock edge.
- R3: At a re-arbitration point, the grant goes to the first requesting master found searching from the index after the last owner upward, wrapping from 5 to 0; the last owner itself is searched last. After reset the search starts at master 0.
- R4: While the owner requests and its done_i bit is low, gnt_o does not change, whatever else requests.
- R5: With park_mode_i equal to 0 (no default) or 3 (treated the same), the grant drops to zero at the edge after a cycle with no request.
- R6: With park_mode_i equal to 1 (last owner), the grant stays with the current owner when no master requests; a zero grant stays zero.
- R7: With park_mode_i equal to 2 (fixed), the grant moves to master park_idx_i when no master requests; a park_idx_i of 6 or 7 gives a zero grant.
- R8: An owner that requests with burst_i and done_i high keeps the grant at that edge while its slot has not expired, even if others request.
- R9: With slot_limit_i = L > 0, the slot expires once the owner has held the grant for L cycles; at the next done_i of the owner a different requesting master, if any, wins by R3.
- R10: With slot_limit_i equal to 0 the slot never expires and a bursting owner keeps the grant indefinitely.
- R11: If the slot has expired and no other master requests, the owner keeps the grant at its done_i and its slot count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Per-master access request |
| burst_i | input | 6 | Per-master flag: wants to keep the port across transfer ends |
| done_i | input | 6 | Per-master transfer-end strobe |
| park_mode_i | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed, 3 none |
| park_idx_i | input | 3 | Master index parked on in fixed mode |
| slot_limit_i | input | 8 | Slot length in cycles, 0 disables burst cutoff |
| gnt_o | output | 6 | One-hot grant, zero when no owner |

## Verification
A vector table drives pairs of competing masters whose pointer positions force the search to wrap, which separates a true rotating pointer from fixed priority, and mixes done and not-done cycles to separate transfer-boundary switching from free switching. Idle cycles under all three parking policies, including an out-of-range fixed index, tell the policies apart. Directed runs with a bursting owner and a rival under slot limits of 0, 1, 2 and 3 distinguish counting exactly L cycles, holding through a mid-transfer expiry, and restarting the count when no rival exists.

// File: rtl/busmat_arb_pkg.sv
package busmat_arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE     = 2'd0,
    PARK_LAST     = 2'd1,
    PARK_FIXED    = 2'd2,
    PARK_NONE_ALT = 2'd3
  } park_mode_e;

endpackage

// File: rtl/busmat_rr_pick.sv
// Round-robin search: offsets 1..N from the last owner, lowest offset wins.
module busmat_rr_pick #(
  parameter int unsigned N_MST = 6,
  parameter int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    int cand;
    found_o = 1'b0;
    idx_o   = last_i;
    for (int k = N_MST; k >= 1; k--) begin
      cand = (int'(last_i) + k) % int'(N_MST);
      if (req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/busmat_slot_timer.sv
module busmat_slot_timer #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [SLOT_W-1:0] limit_i,
  output logic              expired_o
);

  logic [SLOT_W-1:0] cnt_q;
  logic [SLOT_W:0]   held;

  // cycles held including the current one
  assign held      = {1'b0, cnt_q} + (SLOT_W+1)'(1);
  assign expired_o = (limit_i != '0) && (held >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (reload_i)         cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + SLOT_W'(1);
  end

endmodule

// File: rtl/busmat_park_sel.sv
module busmat_park_sel
  import busmat_arb_pkg::*;
#(
  parameter int unsigned N_MST = 6,
  parameter int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [1:0]       mode_i,
  input  logic             own_vld_i,
  input  logic [IDX_W-1:0] own_idx_i,
  input  logic [IDX_W-1:0] fix_idx_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);

  park_mode_e mode;
  assign mode = park_mode_e'(mode_i);

  always_comb begin
    vld_o = 1'b0;
    idx_o = own_idx_i;
    unique case (mode)
      PARK_LAST: begin
        vld_o = own_vld_i;
        idx_o = own_idx_i;
      end
      PARK_FIXED: begin
        vld_o = (int'(fix_idx_i) < int'(N_MST));
        idx_o = fix_idx_i;
      end
      default: vld_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/busmat_slave_arb.sv
module busmat_slave_arb
  import busmat_arb_pkg::*;
#(
  parameter int unsigned N_MST  = 6,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned IDX_W  = $clog2(N_MST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  req_i,
  input  logic [N_MST-1:0]  burst_i,
  input  logic [N_MST-1:0]  done_i,
  input  logic [1:0]        park_mode_i,
  input  logic [IDX_W-1:0]  park_idx_i,
  input  logic [SLOT_W-1:0] slot_limit_i,
  output logic [N_MST-1:0]  gnt_o
);

  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_MST - 1);

  logic             own_vld_q, own_vld_d;
  logic [IDX_W-1:0] own_q, own_d, last_q;
  logic             own_req, own_done, own_burst;
  logic             boundary, keep_burst, reload;
  logic             expired;
  logic             rr_found, park_vld;
  logic [IDX_W-1:0] rr_idx, park_idx;

  assign own_req   = own_vld_q && req_i[own_q];
  assign own_done  = done_i[own_q];
  assign own_burst = burst_i[own_q];

  // re-arbitrate only with no owner, an idle owner, or at a transfer end
  assign boundary   = !own_req || own_done;
  assign keep_burst = own_req && own_done && own_burst && !expired;

  busmat_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
    .req_i   (req_i),
    .last_i  (last_q),
    .found_o (rr_found),
    .idx_o   (rr_idx)
  );

  busmat_park_sel #(.N_MST(N_MST), .IDX_W(IDX_W)) u_park (
    .mode_i    (park_mode_i),
    .own_vld_i (own_vld_q),
    .own_idx_i (own_q),
    .fix_idx_i (park_idx_i),
    .vld_o     (park_vld),
    .idx_o     (park_idx)
  );

  busmat_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reload_i  (reload),
    .limit_i   (slot_limit_i),
    .expired_o (expired)
  );

  always_comb begin
    own_d     = own_q;
    own_vld_d = own_vld_q;
    reload    = 1'b0;
    if (!boundary || keep_burst) begin
      reload = 1'b0;
    end else if (rr_found) begin
      own_d     = rr_idx;
      own_vld_d = 1'b1;
      reload    = 1'b1;
    end else begin
      own_vld_d = park_vld;
      own_d     = park_vld ? park_idx : own_q;
      reload    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      last_q    <= LAST_RST;
    end else begin
      own_vld_q <= own_vld_d;
      own_q     <= own_d;
      if (own_vld_d) last_q <= own_d;
    end
  end

  always_comb begin
    gnt_o = '0;
    if (own_vld_q) gnt_o[own_q] = 1'b1;
  end

  // ---------------------------------------------------------------
  logic others_req;
  assign others_req = |(req_i & ~gnt_o);

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_hold_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_o & req_i & ~done_i)) |=> $stable(gnt_o));

  assert_grant_requester_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(gnt_o & req_i & ~burst_i & done_i)) && (|req_i)) |=> (|(gnt_o & $past(req_i))));

  assert_idle_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i == '0) && (park_mode_i == PARK_NONE || park_mode_i == PARK_NONE_ALT))
      |=> (gnt_o == '0));

  assert_idle_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i == '0) && (park_mode_i == PARK_LAST)) |=> $stable(gnt_o));

  assert_idle_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i == '0) && (park_mode_i == PARK_FIXED) && (int'(park_idx_i) < int'(N_MST)))
      |=> (gnt_o == (N_MST'(1) << $past(park_idx_i))));

  assert_unlimited_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_limit_i == '0) && (|(gnt_o & req_i & burst_i & done_i))) |=> $stable(gnt_o));

  assert_cutoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req && own_done && expired && others_req) |=> !$stable(gnt_o));

  assert_lone_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req && own_done && !others_req) |=> $stable(gnt_o));

endmodule

// File: tb/busmat_slave_arb_bench.sv
module busmat_slave_arb_bench;

  localparam int N = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] req_i = '0, burst_i = '0, done_i = '0;
  logic [1:0] park_mode_i = '0;
  logic [2:0] park_idx_i = '0;
  logic [7:0] slot_limit_i = '0;
  logic [5:0] gnt_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  busmat_slave_arb u_busmat_slave_arb (
    .clk_i, .rst_ni, .req_i, .burst_i, .done_i,
    .park_mode_i, .park_idx_i, .slot_limit_i, .gnt_o
  );

  typedef struct packed {
    logic [5:0] req;
    logic [5:0] burst;
    logic [5:0] done;
    logic [1:0] mode;
    logic [2:0] idx;
    logic [5:0] exp;
    logic [7:0] rq;
  } vec_t;

  // walked continuously from reset; each exp is gnt_o after that vector's edge
  localparam vec_t VECS [15] = '{
    '{6'b000000, 6'b000000, 6'b000000, 2'd0, 3'd0, 6'b000000, 8'd5},
    '{6'b000101, 6'b000000, 6'b000000, 2'd0, 3'd0, 6'b000001, 8'd3},
    '{6'b000101, 6'b000000, 6'b000001, 2'd0, 3'd0, 6'b000100, 8'd3},
    '{6'b000101, 6'b000000, 6'b000000, 2'd0, 3'd0, 6'b000100, 8'd4},
    '{6'b000101, 6'b000000, 6'b000100, 2'd0, 3'd0, 6'b000001, 8'd3},
    '{6'b100001, 6'b000000, 6'b000001, 2'd0, 3'd0, 6'b100000, 8'd3},
    '{6'b100001, 6'b000000, 6'b100000, 2'd0, 3'd0, 6'b000001, 8'd3},
    '{6'b000000, 6'b000000, 6'b000000, 2'd1, 3'd0, 6'b000001, 8'd6},
    '{6'b000000, 6'b000000, 6'b000000, 2'd2, 3'd3, 6'b001000, 8'd7},
    '{6'b000000, 6'b000000, 6'b000000, 2'd3, 3'd0, 6'b000000, 8'd5},
    '{6'b010000, 6'b000000, 6'b000000, 2'd0, 3'd0, 6'b010000, 8'd3},
    '{6'b010010, 6'b010000, 6'b010000, 2'd0, 3'd0, 6'b010000, 8'd8},
    '{6'b010010, 6'b000000, 6'b010000, 2'd0, 3'd0, 6'b000010, 8'd3},
    '{6'b000010, 6'b000000, 6'b000010, 2'd0, 3'd0, 6'b000010, 8'd11},
    '{6'b000000, 6'b000000, 6'b000000, 2'd2, 3'd7, 6'b000000, 8'd7}
  };

  task automatic check(input logic [5:0] exp, input int rq, input string what);
    n_cmp++;
    if (gnt_o !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: gnt_o=%b expected=%b", rq, what, gnt_o, exp);
    end
  endtask

  task automatic drive(input logic [5:0] rq, input logic [5:0] bs, input logic [5:0] dn);
    @(negedge clk_i);
    req_i = rq; burst_i = bs; done_i = dn;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_i = '0; burst_i = '0; done_i = '0;
    park_mode_i = 2'd0; park_idx_i = '0; slot_limit_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1: zero grant during reset even with every master requesting
    req_i = '1;
    repeat (3) @(posedge clk_i);
    #1;
    check(6'b000000, 1, "grant held zero in reset");
    do_reset();

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 15; i++) begin
      @(negedge clk_i);
      park_mode_i = VECS[i].mode;
      park_idx_i  = VECS[i].idx;
      drive(VECS[i].req, VECS[i].burst, VECS[i].done);
      check(VECS[i].exp, int'(VECS[i].rq), $sformatf("vector %0d", i));
    end

    // R9: limit 3, m0 bursting with done every cycle, m1 competing
    do_reset();
    slot_limit_i = 8'd3;
    for (int e = 1; e <= 4; e++) begin
      drive(6'b000011, 6'b000001, 6'b000001);
      check((e < 4) ? 6'b000001 : 6'b000010, 9, $sformatf("limit 3 edge %0d", e));
    end

    // R10: limit 0, m0 keeps through many transfer ends
    do_reset();
    slot_limit_i = 8'd0;
    for (int e = 1; e <= 12; e++) drive(6'b000011, 6'b000001, 6'b000001);
    check(6'b000001, 10, "limit 0 owner never cut");

    // R11: limit 2, lone owner reloads its slot
    do_reset();
    slot_limit_i = 8'd2;
    for (int e = 1; e <= 5; e++) drive(6'b000001, 6'b000001, 6'b000001);
    check(6'b000001, 11, "lone owner kept after expiry");
    drive(6'b000011, 6'b000001, 6'b000001);
    check(6'b000001, 11, "slot restarted, rival waits");
    drive(6'b000011, 6'b000001, 6'b000001);
    check(6'b000010, 11, "rival wins after second slot");

    // R4: expired slot does not cut a beat in flight
    do_reset();
    slot_limit_i = 8'd1;
    drive(6'b000011, 6'b000001, 6'b000000);
    check(6'b000001, 4, "first grant to m0");
    drive(6'b000011, 6'b000001, 6'b000000);
    drive(6'b000011, 6'b000001, 6'b000000);
    check(6'b000001, 4, "expired owner held until done");
    drive(6'b000011, 6'b000001, 6'b000001);
    check(6'b000010, 9, "switch at done after expiry");

    // R2: grant stays one-hot under all-request churn
    do_reset();
    for (int e = 0; e < 8; e++) begin
      drive(6'b111111, 6'b000000, 6'b111111);
      check(6'b000001 << ((e + 0) % N), 3, $sformatf("full rotation step %0d", e));
    end
    n_cmp++;
    if (!$onehot0(gnt_o)) begin
      n_bad++;
      $display("FAIL R2: gnt_o=%b expected one-hot or zero", gnt_o);
    end

    finish_run();
  end

endmodule